// File: doc/BRIEF.md
# Protected Register Write Sequencer

This block keeps two critical 8-bit control registers, power-save control and clock control, safe from stray stores. It sits on a synchronous byte-wide register bus and watches every access from any master. A write to a guarded register takes effect only when the access before it was an unlock write to a separate command register. The value written to the command register does not matter.

If anything else reaches the bus between the unlock and the guarded store, such as an interrupt handler or a DMA master, the store is dropped. A sticky protection-error flag in a status register is then set. Reads of a guarded register need no unlock and leave the unlock standing, so a read-modify-write (bit set, clear or invert) can sit between the unlock and its store. Software clears the error flag by writing 0 to it.

Top module: `prot_reg_seq`

## Requirements
- R1: On reset the power-save register reads 0x00, the clock register reads 0x03, the error flag is 0, the unlock is cleared so a guarded write right after reset is rejected, and bus_rdata is 0x00.
- R2: A write of any value to the command address (0x00) arms the unlock. A following write to the power-save address (0x01) or the clock address (0x02) is committed on the clock edge of its write strobe.
- R3: A write to a guarded address while the unlock is not armed leaves the register unchanged and sets the error flag on that same edge.
- R4: Any access to an address that is neither guarded nor the command address, read or write (status reads and writes included), clears the unlock. The following guarded write is then rejected and raises the error flag.
- R5: An unlock is used up by one guarded write. A second guarded write with no new unlock is rejected and sets the error flag.
- R6: A read of a guarded address returns its current value and keeps the unlock. This lets a read-modify-write commit its write phase.
- R7: A read of the command address returns 0x00 and neither arms nor clears the unlock.
- R8: The status register at address 0x03 holds the error flag in bit 0, and its other bits read 0. A status write needs no unlock. Writing bit 0 = 0 clears the flag. Writing bit 0 = 1 does nothing, so the flag stays set until it is cleared.
- R9: Read data is registered. It appears on bus_rdata after the edge that samples the read strobe and holds until the next read. A read of an unmapped address returns 0x00.
- R10: When write and read strobes are both high in one cycle, the access is handled as a write only, and bus_rdata keeps its previous value.
- R11: A write to the command address while the unlock is already armed leaves it armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwr_ctrl | output | 8 | Current power-save control value |
| clk_ctrl | output | 8 | Current clock control value |
| prot_err | output | 1 | Sticky protection-error flag |

## Verification
A guarded store, a rejected store and a status write all take effect on the clock edge that samples their strobe. So pwr_ctrl, clk_ctrl and prot_err are due one edge after the access is driven. Read data takes one edge, through a single register, to reach bus_rdata. The bench drives every access on a falling edge and removes it on the next falling edge. It then reads the outputs there, half a period after the edge that should have updated them. A behavioural model advanced on each rising edge is compared at every falling edge, and named directed checks confirm each corner value.

// File: rtl/prs_pkg.sv
package prs_pkg;
  // Class of the bus access made in the current cycle
  typedef enum logic [2:0] {
    K_IDLE,
    K_CMD,
    K_GUARD,
    K_STAT,
    K_OTHER
  } acc_kind_t;
endpackage

// File: rtl/prs_decode.sv
module prs_decode
  import prs_pkg::*;
#(
  parameter int                          ADDR_W      = 8,
  parameter int                          NUM_GUARD   = 2,
  parameter logic [ADDR_W-1:0]           CMD_ADDR    = 8'h00,
  parameter logic [ADDR_W-1:0]           STAT_ADDR   = 8'h03,
  parameter logic [NUM_GUARD*ADDR_W-1:0] GUARD_ADDRS = 16'h0201
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic                 rd,
  output acc_kind_t            kind,
  output logic                 is_wr,
  output logic [NUM_GUARD-1:0] gsel
);
  for (genvar g = 0; g < NUM_GUARD; g++) begin : g_cmp
    assign gsel[g] = (addr == GUARD_ADDRS[g*ADDR_W +: ADDR_W]);
  end

  // A cycle with both strobes high counts as a write
  assign is_wr = wr;

  always_comb begin
    if (!(wr || rd))              kind = K_IDLE;
    else if (addr == CMD_ADDR)    kind = K_CMD;
    else if (|gsel)               kind = K_GUARD;
    else if (addr == STAT_ADDR)   kind = K_STAT;
    else                          kind = K_OTHER;
  end
endmodule

// File: rtl/prs_unlock.sv
module prs_unlock
  import prs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  acc_kind_t kind,
  input  logic      is_wr,
  input  logic      clr_bit,
  output logic      armed,
  output logic      commit,
  output logic      prot_err
);
  logic viol;

  assign commit = (kind == K_GUARD) && is_wr && armed;
  assign viol   = (kind == K_GUARD) && is_wr && !armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      prot_err <= 1'b0;
    end else begin
      unique case (kind)
        K_CMD:   if (is_wr) armed <= 1'b1;
        K_GUARD: if (is_wr) armed <= 1'b0;
        K_STAT,
        K_OTHER: armed <= 1'b0;
        default: ;
      endcase
      if (viol)
        prot_err <= 1'b1;
      else if ((kind == K_STAT) && is_wr && !clr_bit)
        prot_err <= 1'b0;
    end
  end
endmodule

// File: rtl/prs_guard_bank.sv
module prs_guard_bank #(
  parameter int                          DATA_W    = 8,
  parameter int                          NUM_GUARD = 2,
  parameter logic [NUM_GUARD*DATA_W-1:0] RST_VALS  = 16'h0300
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        commit,
  input  logic [NUM_GUARD-1:0]        gsel,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_GUARD*DATA_W-1:0] regs_flat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      regs_flat <= RST_VALS;
    end else begin
      for (int g = 0; g < NUM_GUARD; g++) begin
        if (commit && gsel[g])
          regs_flat[g*DATA_W +: DATA_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/prot_reg_seq.sv
module prot_reg_seq
  import prs_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 8'h01,
  parameter logic [ADDR_W-1:0] CLK_ADDR  = 8'h02,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h03,
  parameter logic [DATA_W-1:0] PWR_RST   = 8'h00,
  parameter logic [DATA_W-1:0] CLK_RST   = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] pwr_ctrl,
  output logic [DATA_W-1:0] clk_ctrl,
  output logic              prot_err
);
  localparam int NUM_GUARD = 2;
  localparam logic [NUM_GUARD*ADDR_W-1:0] GUARD_ADDRS = {CLK_ADDR, PWR_ADDR};
  localparam logic [NUM_GUARD*DATA_W-1:0] RST_VALS    = {CLK_RST, PWR_RST};

  acc_kind_t                   kind;
  logic                        is_wr;
  logic [NUM_GUARD-1:0]        gsel;
  logic                        armed;
  logic                        commit;
  logic [NUM_GUARD*DATA_W-1:0] regs_flat;
  logic [DATA_W-1:0]           rd_mux;

  prs_decode #(
    .ADDR_W(ADDR_W), .NUM_GUARD(NUM_GUARD), .CMD_ADDR(CMD_ADDR),
    .STAT_ADDR(STAT_ADDR), .GUARD_ADDRS(GUARD_ADDRS)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .kind(kind), .is_wr(is_wr), .gsel(gsel)
  );

  prs_unlock u_trk (
    .clk(clk), .rst(rst), .kind(kind), .is_wr(is_wr),
    .clr_bit(bus_wdata[0]), .armed(armed), .commit(commit),
    .prot_err(prot_err)
  );

  prs_guard_bank #(
    .DATA_W(DATA_W), .NUM_GUARD(NUM_GUARD), .RST_VALS(RST_VALS)
  ) u_bank (
    .clk(clk), .rst(rst), .commit(commit), .gsel(gsel),
    .wdata(bus_wdata), .regs_flat(regs_flat)
  );

  assign pwr_ctrl = regs_flat[0 +: DATA_W];
  assign clk_ctrl = regs_flat[DATA_W +: DATA_W];

  always_comb begin
    rd_mux = '0;
    unique case (kind)
      K_GUARD: begin
        for (int g = 0; g < NUM_GUARD; g++)
          if (gsel[g]) rd_mux = regs_flat[g*DATA_W +: DATA_W];
      end
      K_STAT:  rd_mux = {{(DATA_W-1){1'b0}}, prot_err};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                 bus_rdata <= '0;
    else if (bus_rd && !is_wr) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 8'h01,
  parameter logic [ADDR_W-1:0] CLK_ADDR  = 8'h02,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h03,
  parameter logic [DATA_W-1:0] PWR_RST   = 8'h00,
  parameter logic [DATA_W-1:0] CLK_RST   = 8'h03
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] pwr_ctrl,
  input logic [DATA_W-1:0] clk_ctrl,
  input logic              prot_err,
  input logic              armed
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: one edge after reset the defaults are present
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1)
      p_reset_vals_r1: assert (pwr_ctrl == PWR_RST && clk_ctrl == CLK_RST && !prot_err);
  end

  p_commit_pwr_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == PWR_ADDR && armed) |=> (pwr_ctrl == $past(bus_wdata)));

  p_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == PWR_ADDR || bus_addr == CLK_ADDR) && !armed)
      |=> (prot_err && $stable(pwr_ctrl) && $stable(clk_ctrl)));

  p_pwr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == PWR_ADDR) |=> $stable(pwr_ctrl));

  p_clk_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == CLK_ADDR) |=> $stable(clk_ctrl));

  p_disarm_r4: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && bus_addr != CMD_ADDR && bus_addr != PWR_ADDR
      && bus_addr != CLK_ADDR) |=> !armed);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (prot_err && !(bus_wr && bus_addr == STAT_ADDR && !bus_wdata[0])) |=> prot_err);

  p_cmd_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == CMD_ADDR) |=> (bus_rdata == '0));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind prot_reg_seq prs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR), .PWR_ADDR(PWR_ADDR),
  .CLK_ADDR(CLK_ADDR), .STAT_ADDR(STAT_ADDR), .PWR_RST(PWR_RST), .CLK_RST(CLK_RST)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_ctrl(pwr_ctrl),
  .clk_ctrl(clk_ctrl), .prot_err(prot_err), .armed(armed)
);

// File: tb/test_prot_reg_seq.sv
`timescale 1ns/1ps
module test_prot_reg_seq;
  localparam logic [7:0] A_CMD = 8'h00, A_PWR = 8'h01, A_CLK = 8'h02,
                         A_STAT = 8'h03, A_FREE = 8'h20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, pwr_ctrl, clk_ctrl;
  logic       prot_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit       m_arm;
  bit [7:0] m_pwr, m_clk, m_rdata;
  bit       m_err;

  always #2 clk = ~clk;

  prot_reg_seq i_prot_reg_seq (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_ctrl(pwr_ctrl),
    .clk_ctrl(clk_ctrl), .prot_err(prot_err)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_arm = 0; m_pwr = 8'h00; m_clk = 8'h03; m_err = 0; m_rdata = 8'h00;
    end else if (bus_wr) begin
      if (bus_addr == A_CMD) m_arm = 1;
      else if (bus_addr == A_PWR || bus_addr == A_CLK) begin
        if (m_arm) begin
          if (bus_addr == A_PWR) m_pwr = bus_wdata; else m_clk = bus_wdata;
        end else m_err = 1;
        m_arm = 0;
      end else begin
        if (bus_addr == A_STAT && !bus_wdata[0]) m_err = 0;
        m_arm = 0;
      end
    end else if (bus_rd) begin
      if (bus_addr == A_CMD) m_rdata = 0;
      else if (bus_addr == A_PWR) m_rdata = m_pwr;
      else if (bus_addr == A_CLK) m_rdata = m_clk;
      else begin
        m_rdata = (bus_addr == A_STAT) ? {7'b0, m_err} : 8'h00;
        m_arm = 0;
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // model comparison on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("model pwr", pwr_ctrl, m_pwr);
      check("model clk", clk_ctrl, m_clk);
      check("model err", {7'b0, prot_err}, {7'b0, m_err});
      check("model rdata", bus_rdata, m_rdata);
    end
  end

  task automatic acc(bit w, bit r, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d); acc(1, 0, a, d); endtask
  task automatic rd(logic [7:0] a); acc(0, 1, a, 8'h00); endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 pwr reset", pwr_ctrl, 8'h00);
    check("R1 clk reset", clk_ctrl, 8'h03);
    check("R1 err reset", {7'b0, prot_err}, 8'h00);
    check("R1 rdata reset", bus_rdata, 8'h00);

    wr(A_PWR, 8'h55);
    check("R3 pwr kept", pwr_ctrl, 8'h00);
    check("R3 err set", {7'b0, prot_err}, 8'h01);
    rd(A_STAT);
    check("R8 status read", bus_rdata, 8'h01);
    wr(A_STAT, 8'hFF);
    check("R8 write one keeps", {7'b0, prot_err}, 8'h01);
    wr(A_STAT, 8'hFE);
    check("R8 write zero clears", {7'b0, prot_err}, 8'h00);

    wr(A_CMD, 8'hA5); wr(A_PWR, 8'h5A);
    check("R2 pwr commit", pwr_ctrl, 8'h5A);
    check("R2 no err", {7'b0, prot_err}, 8'h00);
    wr(A_CMD, 8'h00); wr(A_CLK, 8'h81);
    check("R2 clk commit", clk_ctrl, 8'h81);

    wr(A_CLK, 8'h42);
    check("R5 second write dropped", clk_ctrl, 8'h81);
    check("R5 err", {7'b0, prot_err}, 8'h01);
    wr(A_STAT, 8'h00);

    wr(A_CMD, 8'h11); rd(A_STAT); wr(A_PWR, 8'h11);
    check("R4 status read disarms", pwr_ctrl, 8'h5A);
    check("R4 err", {7'b0, prot_err}, 8'h01);
    wr(A_STAT, 8'h00);
    wr(A_CMD, 8'h22); wr(A_FREE, 8'h77); wr(A_CLK, 8'h22);
    check("R4 unmapped write disarms", clk_ctrl, 8'h81);
    wr(A_STAT, 8'h00);

    rd(A_PWR);
    check("R6 read guarded", bus_rdata, 8'h5A);
    wr(A_CMD, 8'h33); rd(A_CLK);
    check("R6 rmw read", bus_rdata, 8'h81);
    wr(A_CLK, 8'h80);
    check("R6 rmw commit", clk_ctrl, 8'h80);
    check("R6 no err", {7'b0, prot_err}, 8'h00);

    wr(A_CMD, 8'h44); rd(A_CMD);
    check("R7 cmd reads zero", bus_rdata, 8'h00);
    wr(A_PWR, 8'h33);
    check("R7 unlock kept", pwr_ctrl, 8'h33);

    wr(A_CMD, 8'h01); wr(A_CMD, 8'h02); wr(A_PWR, 8'h44);
    check("R11 rearm", pwr_ctrl, 8'h44);
    check("R11 no err", {7'b0, prot_err}, 8'h00);

    rd(A_CLK);
    repeat (3) @(negedge clk);
    check("R9 rdata held", bus_rdata, 8'h80);
    rd(A_FREE);
    check("R9 unmapped zero", bus_rdata, 8'h00);

    rd(A_PWR);
    wr(A_CMD, 8'h00); acc(1, 1, A_PWR, 8'h99);
    check("R10 write taken", pwr_ctrl, 8'h99);
    check("R10 rdata unchanged", bus_rdata, 8'h44);

    wr(A_CMD, 8'h00);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 clk after reset", clk_ctrl, 8'h03);
    check("R1 pwr after reset", pwr_ctrl, 8'h00);
    wr(A_PWR, 8'h12);
    check("R1 unlock cleared", pwr_ctrl, 8'h00);
    check("R1 err on stale unlock", {7'b0, prot_err}, 8'h01);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule